// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the register file that software programs to drive a sixteen-channel DMA controller. A word-wide register bus (byte address, write enable, write data and read data) reaches five parameter registers in each channel: a start word address, a row length, a row count, a control word and a line pitch. The bank passes these values to the per-channel transfer engines. The last step of a channel's setup is the write to its address register, and that write issues a one-cycle start pulse to the engine.

A group of shared registers serves all channels. One register issues per-channel abort pulses. One holds the interrupt status, which is cleared by writing ones. The interrupt-enable and loop-control registers each have a plain write location and a separate location that clears only the bits written as one. Every engine reports completion and half-buffer events. These events set the status bits, and the bank folds status and enable into a single interrupt line. When software reads a channel's address register it gets the engine's live word address, which it can use to work out how many bytes remain.

Top module: `dma_ctrl_regbank`

## Requirements
- R1: After reset every register location reads zero, and the start, stop, loop-mode and interrupt outputs are all low.
- R2: Channel n's registers sit at byte address n*0x10. Row length is at +0x4 and row count is at +0x8, each 16 bits. Control is at +0xC, 6 bits: [3:0] channel number, bit 4 burst of four words, bit 5 direction (1 memory-to-device). Write-data bits above a field are dropped and read back as zero. A write to one channel leaves the other channels unchanged.
- R3: Channel n's 16-bit line pitch is at 0x100 + 4*n and is presented on that channel's pitch output.
- R4: A write to offset +0x0 of channel n stores bits [29:0] as the start word address and raises only ch_start_o[n] for exactly the one cycle that follows the write. Writes to any other register raise no start.
- R5: A read of offset +0x0 of channel n returns that channel's live current word address input, zero-extended. It does not return the stored start address.
- R6: Writing 0x140 with bit n set raises ch_stop_o[n] for the one cycle that follows the write. Zero bits and bits 31:16 raise nothing. 0x140 reads zero.
- R7: Status at 0x144. A done or half-buffer event on channel n sets bit n in the next cycle, whatever its enable is. Writing 1 to bit n clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as a clear wins, so the bit stays set.
- R8: Enable at 0x148 is written directly from bits [15:0] and read back. Writing 1s at 0x14C clears the matching enable bits and zeros have no effect. 0x14C reads zero.
- R9: Loop control at 0x150 is written directly and read back, using bits [15:0] and [31:16]. Writing 1s at 0x15C clears the matching bits and zeros have no effect. 0x15C reads zero. ch_loop_o[n] is high only when both bit n and bit n+16 are set.
- R10: irq_o is high exactly when some channel has both its status bit and its enable bit set.
- R11: Unused offsets (0x154, 0x158, 0x160 to 0x1FC) read zero, and writes to them change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | 9 | Register byte address (bits 1:0 ignored) |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, same cycle |
| ch_cur_addr_i | input | NUM_CH*WADDR_W | Live word address of each engine |
| ch_done_i | input | NUM_CH | Transfer-complete events |
| ch_half_i | input | NUM_CH | Half-buffer events |
| ch_start_o | output | NUM_CH | One-cycle start pulses |
| ch_stop_o | output | NUM_CH | One-cycle abort pulses |
| ch_loop_o | output | NUM_CH | Loop mode enabled per channel |
| ch_addr_o | output | NUM_CH*WADDR_W | Start word address per channel |
| ch_rowlen_o | output | NUM_CH*LEN_W | Row length per channel |
| ch_rowcnt_o | output | NUM_CH*LEN_W | Row count per channel |
| ch_ctrl_o | output | NUM_CH*6 | Control word per channel |
| ch_pitch_o | output | NUM_CH*LEN_W | Line pitch per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
Each of the sixteen channels gets its own parameter pattern. The values differ per channel and carry junk in the upper bits, and reading every channel back after all writes exposes decode aliasing and field truncation. The start sweep writes one address at a time and shows that the pulse goes to one channel only and is not raised by the other registers. The event sweep raises completion and half-buffer events on each channel against enable and clear combinations, including a clear that collides with an event, to separate set-wins from clear-wins and enabled from masked interrupts. The loop sweep writes all four combinations of each channel's bit pair to show that loop mode needs both bits.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned REG_AW  = 9;
    localparam int unsigned CTRL_W  = 6;
    localparam int unsigned LOOP_HI = 16;

    localparam logic [REG_AW-1:0] OFS_PITCH    = 9'h100;
    localparam logic [REG_AW-1:0] OFS_STOP     = 9'h140;
    localparam logic [REG_AW-1:0] OFS_ISTS     = 9'h144;
    localparam logic [REG_AW-1:0] OFS_IEN      = 9'h148;
    localparam logic [REG_AW-1:0] OFS_IEN_CLR  = 9'h14C;
    localparam logic [REG_AW-1:0] OFS_LOOP     = 9'h150;
    localparam logic [REG_AW-1:0] OFS_LOOP_CLR = 9'h15C;

    typedef enum logic [1:0] {
        CREG_ADDR   = 2'd0,
        CREG_ROWLEN = 2'd1,
        CREG_ROWCNT = 2'd2,
        CREG_CTRL   = 2'd3
    } creg_e;

    typedef struct packed {
        logic stop;
        logic ists;
        logic ien;
        logic ien_clr;
        logic loop;
        logic loop_clr;
    } shared_wr_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regbank_pkg::*;
#(
    parameter int unsigned WADDR_W = 30,
    parameter int unsigned LEN_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  creg_e              sel_i,
    input  logic               pitch_wr_i,
    input  logic [BUS_W-1:0]   wdata_i,
    input  logic [WADDR_W-1:0] cur_addr_i,
    output logic [BUS_W-1:0]   rd_o,
    output logic [WADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]   rowlen_o,
    output logic [LEN_W-1:0]   rowcnt_o,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic [LEN_W-1:0]   pitch_o,
    output logic               start_o
);
    logic unused_wbits;
    assign unused_wbits = &{1'b0, wdata_i[BUS_W-1:WADDR_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o   <= '0;
            rowlen_o <= '0;
            rowcnt_o <= '0;
            ctrl_o   <= '0;
            pitch_o  <= '0;
            start_o  <= 1'b0;
        end else begin
            start_o <= 1'b0;
            if (wr_i) begin
                unique case (sel_i)
                    CREG_ADDR: begin
                        addr_o  <= wdata_i[WADDR_W-1:0];
                        start_o <= 1'b1;
                    end
                    CREG_ROWLEN: rowlen_o <= wdata_i[LEN_W-1:0];
                    CREG_ROWCNT: rowcnt_o <= wdata_i[LEN_W-1:0];
                    CREG_CTRL:   ctrl_o   <= wdata_i[CTRL_W-1:0];
                endcase
            end
            if (pitch_wr_i) begin
                pitch_o <= wdata_i[LEN_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (sel_i)
            CREG_ADDR:   rd_o = BUS_W'(cur_addr_i);
            CREG_ROWLEN: rd_o = BUS_W'(rowlen_o);
            CREG_ROWCNT: rd_o = BUS_W'(rowcnt_o);
            CREG_CTRL:   rd_o = BUS_W'(ctrl_o);
        endcase
    end

    // R4: a start pulse only ever follows an address-register write
    a_r4_start_after_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(wr_i && sel_i == CREG_ADDR));

    // R2: parameters hold when the channel was not written
    a_r2_params_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_i) |-> ($stable(rowlen_o) && $stable(rowcnt_o) && $stable(ctrl_o)));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shared_wr_t        wr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [NUM_CH-1:0] evt_i,
    output logic [NUM_CH-1:0] stop_o,
    output logic [NUM_CH-1:0] sts_o,
    output logic [NUM_CH-1:0] en_o,
    output logic [BUS_W-1:0]  loop_o,
    output logic [NUM_CH-1:0] loop_on_o,
    output logic              irq_o
);
    localparam logic [BUS_W-1:0] LANE      = BUS_W'((64'd1 << NUM_CH) - 64'd1);
    localparam logic [BUS_W-1:0] LOOP_MASK = LANE | (LANE << LOOP_HI);

    logic [NUM_CH-1:0] wlo;
    assign wlo = wdata_i[NUM_CH-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_o <= '0;
            sts_o  <= '0;
            en_o   <= '0;
            loop_o <= '0;
        end else begin
            stop_o <= wr_i.stop ? wlo : '0;
            sts_o  <= (wr_i.ists ? (sts_o & ~wlo) : sts_o) | evt_i;
            if (wr_i.ien) begin
                en_o <= wlo;
            end else if (wr_i.ien_clr) begin
                en_o <= en_o & ~wlo;
            end
            if (wr_i.loop) begin
                loop_o <= wdata_i & LOOP_MASK;
            end else if (wr_i.loop_clr) begin
                loop_o <= loop_o & ~wdata_i;
            end
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_loop
        assign loop_on_o[n] = loop_o[n] & loop_o[n + LOOP_HI];
    end

    assign irq_o = |(sts_o & en_o);

    // R7: an event always leaves its status bit set
    a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((sts_o & $past(evt_i)) == $past(evt_i)));

    // R7: a one written to status clears the bit when no event collides
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.ists |=> ((sts_o & $past(wlo & ~evt_i)) == '0));

    // R8: the enable clear alias removes every bit written as one
    a_r8_alias_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.ien_clr |=> ((en_o & $past(wlo)) == '0));

    // R9: clearing either half of a pair drops loop mode
    a_r9_loop_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.loop_clr |=> ((loop_on_o & $past(wlo | wdata_i[LOOP_HI +: NUM_CH])) == '0));

    // R6: stop pulses only follow a stop write and only on written bits
    a_r6_stop_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|stop_o) |-> ($past(wr_i.stop) && ((stop_o & ~$past(wlo)) == '0)));
endmodule

// File: rtl/dma_ctrl_regbank.sv
module dma_ctrl_regbank
    import dma_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH  = 16,
    parameter int unsigned WADDR_W = 30,
    parameter int unsigned LEN_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [REG_AW-1:0]          reg_addr_i,
    input  logic                       reg_we_i,
    input  logic [BUS_W-1:0]           reg_wdata_i,
    output logic [BUS_W-1:0]           reg_rdata_o,
    input  logic [NUM_CH*WADDR_W-1:0]  ch_cur_addr_i,
    input  logic [NUM_CH-1:0]          ch_done_i,
    input  logic [NUM_CH-1:0]          ch_half_i,
    output logic [NUM_CH-1:0]          ch_start_o,
    output logic [NUM_CH-1:0]          ch_stop_o,
    output logic [NUM_CH-1:0]          ch_loop_o,
    output logic [NUM_CH*WADDR_W-1:0]  ch_addr_o,
    output logic [NUM_CH*LEN_W-1:0]    ch_rowlen_o,
    output logic [NUM_CH*LEN_W-1:0]    ch_rowcnt_o,
    output logic [NUM_CH*CTRL_W-1:0]   ch_ctrl_o,
    output logic [NUM_CH*LEN_W-1:0]    ch_pitch_o,
    output logic                       irq_o
);
    localparam int unsigned IDX_W = 4;

    logic             chan_hit, pitch_hit;
    logic [IDX_W-1:0] chan_idx, pitch_idx;
    creg_e            creg_sel;
    shared_wr_t       shared_wr;
    logic [REG_AW-3:0] wsel;

    logic unused_alow;
    assign unused_alow = &{1'b0, reg_addr_i[1:0]};

    always_comb begin
        wsel      = reg_addr_i[REG_AW-1:2];
        chan_idx  = reg_addr_i[7:4];
        pitch_idx = reg_addr_i[5:2];
        creg_sel  = creg_e'(reg_addr_i[3:2]);
        chan_hit  = !reg_addr_i[8] && (int'(chan_idx) < NUM_CH);
        pitch_hit = (reg_addr_i[8:6] == OFS_PITCH[8:6]) && (int'(pitch_idx) < NUM_CH);
        shared_wr.stop     = reg_we_i && (wsel == OFS_STOP[REG_AW-1:2]);
        shared_wr.ists     = reg_we_i && (wsel == OFS_ISTS[REG_AW-1:2]);
        shared_wr.ien      = reg_we_i && (wsel == OFS_IEN[REG_AW-1:2]);
        shared_wr.ien_clr  = reg_we_i && (wsel == OFS_IEN_CLR[REG_AW-1:2]);
        shared_wr.loop     = reg_we_i && (wsel == OFS_LOOP[REG_AW-1:2]);
        shared_wr.loop_clr = reg_we_i && (wsel == OFS_LOOP_CLR[REG_AW-1:2]);
    end

    logic [BUS_W-1:0] chan_rd   [NUM_CH];
    logic [LEN_W-1:0] pitch_arr [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dma_chan_regs #(
            .WADDR_W (WADDR_W),
            .LEN_W   (LEN_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (reg_we_i && chan_hit && (chan_idx == IDX_W'(g))),
            .sel_i      (creg_sel),
            .pitch_wr_i (reg_we_i && pitch_hit && (pitch_idx == IDX_W'(g))),
            .wdata_i    (reg_wdata_i),
            .cur_addr_i (ch_cur_addr_i[g*WADDR_W +: WADDR_W]),
            .rd_o       (chan_rd[g]),
            .addr_o     (ch_addr_o[g*WADDR_W +: WADDR_W]),
            .rowlen_o   (ch_rowlen_o[g*LEN_W +: LEN_W]),
            .rowcnt_o   (ch_rowcnt_o[g*LEN_W +: LEN_W]),
            .ctrl_o     (ch_ctrl_o[g*CTRL_W +: CTRL_W]),
            .pitch_o    (pitch_arr[g]),
            .start_o    (ch_start_o[g])
        );
        assign ch_pitch_o[g*LEN_W +: LEN_W] = pitch_arr[g];
    end

    logic [NUM_CH-1:0] sts, en;
    logic [BUS_W-1:0]  loop_reg;

    dma_irq_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (shared_wr),
        .wdata_i   (reg_wdata_i),
        .evt_i     (ch_done_i | ch_half_i),
        .stop_o    (ch_stop_o),
        .sts_o     (sts),
        .en_o      (en),
        .loop_o    (loop_reg),
        .loop_on_o (ch_loop_o),
        .irq_o     (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (chan_hit) begin
            reg_rdata_o = chan_rd[chan_idx];
        end else if (pitch_hit) begin
            reg_rdata_o = BUS_W'(pitch_arr[pitch_idx]);
        end else if (wsel == OFS_ISTS[REG_AW-1:2]) begin
            reg_rdata_o = BUS_W'(sts);
        end else if (wsel == OFS_IEN[REG_AW-1:2]) begin
            reg_rdata_o = BUS_W'(en);
        end else if (wsel == OFS_LOOP[REG_AW-1:2]) begin
            reg_rdata_o = loop_reg;
        end
    end
endmodule

// File: tb/dma_ctrl_regbank_tb_top.sv
module dma_ctrl_regbank_tb_top;
    localparam int NC = 16;
    localparam int WA = 30;
    localparam int LW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [8:0]        reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NC*WA-1:0]  cur_addr = '0;
    logic [NC-1:0]     done_v = '0, half_v = '0;
    logic [NC-1:0]     ch_start_o, ch_stop_o, ch_loop_o;
    logic [NC*WA-1:0]  ch_addr_o;
    logic [NC*LW-1:0]  ch_rowlen_o, ch_rowcnt_o, ch_pitch_o;
    logic [NC*6-1:0]   ch_ctrl_o;
    logic              irq_o;

    int checks = 0;
    int fails  = 0;
    logic [NC-1:0] snap_start, snap_stop;

    always #5 clk = ~clk;

    dma_ctrl_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ch_cur_addr_i(cur_addr),
        .ch_done_i(done_v), .ch_half_i(half_v), .ch_start_o(ch_start_o),
        .ch_stop_o(ch_stop_o), .ch_loop_o(ch_loop_o), .ch_addr_o(ch_addr_o),
        .ch_rowlen_o(ch_rowlen_o), .ch_rowcnt_o(ch_rowcnt_o), .ch_ctrl_o(ch_ctrl_o),
        .ch_pitch_o(ch_pitch_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        snap_start = ch_start_o;
        snap_stop  = ch_stop_o;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1 d = reg_rdata;
    endtask

    task automatic evt(input logic [NC-1:0] dn, input logic [NC-1:0] hf);
        @(negedge clk);
        done_v = dn; half_v = hf;
        @(negedge clk);
        done_v = '0; half_v = '0;
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, exp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state over the whole map
        for (int a = 0; a < 512; a += 4) begin
            rd(9'(a), v);
            chk($sformatf("R1 reset read %h", a), v, 32'h0);
        end
        chk("R1 outputs after reset", {28'h0, |ch_start_o, |ch_stop_o, |ch_loop_o, irq_o}, 32'h0);
        chk("R1 params after reset", {29'h0, |ch_addr_o, |ch_rowlen_o, |ch_ctrl_o}, 32'h0);

        // R2 and R3: per-channel parameter sweep
        for (int ch = 0; ch < NC; ch++) begin
            logic [31:0] rl, rc, ct, pt;
            rl = 32'h5A5A_0000 | 32'(ch * 16'h0123 + 1);
            rc = 32'hC3C3_0000 | 32'(16'hFFFF - ch * 16'h0101);
            ct = 32'hFFFF_FF00 | 32'(ch) | (32'(ch % 2) << 4) | (32'((ch / 2) % 2) << 5);
            pt = 32'hDEAD_0000 | 32'(ch * 16'h0777 + 3);
            wr(9'(ch * 16 + 4), rl);
            chk("R4 no start on row length write", 32'(snap_start), 32'h0);
            wr(9'(ch * 16 + 8), rc);
            wr(9'(ch * 16 + 12), ct);
            wr(9'(256 + ch * 4), pt);
            chk("R4 no start on pitch write", 32'(snap_start), 32'h0);
            rd(9'(ch * 16 + 4), v);  chk("R2 row length read", v, rl & 32'hFFFF);
            rd(9'(ch * 16 + 8), v);  chk("R2 row count read", v, rc & 32'hFFFF);
            rd(9'(ch * 16 + 12), v); chk("R2 control read", v, ct & 32'h3F);
            rd(9'(256 + ch * 4), v); chk("R3 pitch read", v, pt & 32'hFFFF);
            chk("R2 row length out", 32'(ch_rowlen_o[ch*LW +: LW]), rl & 32'hFFFF);
            chk("R2 control out", 32'(ch_ctrl_o[ch*6 +: 6]), ct & 32'h3F);
            chk("R3 pitch out", 32'(ch_pitch_o[ch*LW +: LW]), pt & 32'hFFFF);
        end
        for (int ch = 0; ch < NC; ch++) begin
            rd(9'(ch * 16 + 4), v);
            chk("R2 no cross-channel alias", v, 32'(ch * 16'h0123 + 1) & 32'hFFFF);
            chk("R2 row count out kept", 32'(ch_rowcnt_o[ch*LW +: LW]),
                32'(16'hFFFF - ch * 16'h0101) & 32'hFFFF);
        end

        // R4: address write starts exactly one channel for one cycle
        for (int ch = 0; ch < NC; ch++) begin
            v = 32'hC000_0000 | (32'(ch) << 20) | 32'h1234;
            wr(9'(ch * 16), v);
            chk("R4 start pulse one-hot", 32'(snap_start), 32'(1) << ch);
            chk("R4 stored word address", 32'(ch_addr_o[ch*WA +: WA]), v & 32'h3FFF_FFFF);
            @(negedge clk);
            chk("R4 start lasts one cycle", 32'(ch_start_o), 32'h0);
        end

        // R5: address reads return the live engine position
        for (int ch = 0; ch < NC; ch++) begin
            cur_addr[ch*WA +: WA] = 30'(ch * 32'h0100_0001 + 7);
        end
        for (int ch = 0; ch < NC; ch++) begin
            rd(9'(ch * 16), v);
            chk("R5 live address read", v, 32'(30'(ch * 32'h0100_0001 + 7)));
        end

        // R6: stop pulses
        wr(9'h140, 32'h0000_8421);
        chk("R6 stop pulse pattern", 32'(snap_stop), 32'h8421);
        @(negedge clk);
        chk("R6 stop lasts one cycle", 32'(ch_stop_o), 32'h0);
        wr(9'h140, 32'hFFFF_0000);
        chk("R6 upper stop bits inert", 32'(snap_stop), 32'h0);
        rd(9'h140, v); chk("R6 stop reads zero", v, 32'h0);

        // R7 with R10: status behaviour while masked
        for (int ch = 0; ch < NC; ch++) begin
            logic [NC-1:0] b;
            b = NC'(1) << ch;
            if (ch % 2 == 0) evt(b, '0); else evt('0, b);
            rd(9'h144, v); chk("R7 event sets status", v, 32'(b));
            chk("R10 masked event no irq", 32'(irq_o), 32'h0);
            wr(9'h144, 32'h0);
            rd(9'h144, v); chk("R7 zero write no effect", v, 32'(b));
            wr(9'h144, ~32'(b));
            rd(9'h144, v); chk("R7 other ones no effect", v, 32'(b));
            wr(9'h144, 32'(b));
            rd(9'h144, v); chk("R7 one clears", v, 32'h0);
            @(negedge clk);
            reg_addr = 9'h144; reg_wdata = 32'(b); reg_we = 1'b1; done_v = b;
            @(negedge clk);
            reg_we = 1'b0; done_v = '0;
            rd(9'h144, v); chk("R7 event beats clear", v, 32'(b));
            wr(9'h144, 32'(b));
        end

        // R8: enable register and its clear alias
        wr(9'h148, 32'hFFFF_A5C3);
        rd(9'h148, v); chk("R8 enable write", v, 32'h0000_A5C3);
        wr(9'h14C, 32'h0000_00C0);
        rd(9'h148, v); chk("R8 alias clears ones", v, 32'h0000_A503);
        wr(9'h14C, 32'h0);
        rd(9'h148, v); chk("R8 alias zeros no effect", v, 32'h0000_A503);
        wr(9'h14C, 32'hFFFF_0000);
        rd(9'h148, v); chk("R8 alias upper bits no effect", v, 32'h0000_A503);
        rd(9'h14C, v); chk("R8 alias reads zero", v, 32'h0);

        // R10: interrupt combination per channel
        for (int ch = 0; ch < NC; ch++) begin
            logic [NC-1:0] b;
            b = NC'(1) << ch;
            wr(9'h148, 32'(NC'(1) << ((ch + 1) % NC)));
            evt('0, b);
            chk("R10 enable on other channel", 32'(irq_o), 32'h0);
            wr(9'h148, 32'(b));
            chk("R10 status and enable", 32'(irq_o), 32'h1);
            wr(9'h14C, 32'(b));
            chk("R10 enable cleared", 32'(irq_o), 32'h0);
            rd(9'h144, v); chk("R7 status kept when disabled", v, 32'(b));
            wr(9'h148, 32'(b));
            wr(9'h144, 32'(b));
            chk("R10 status cleared", 32'(irq_o), 32'h0);
        end

        // R9: loop pair sweep
        for (int ch = 0; ch < NC; ch++) begin
            for (int c = 0; c < 4; c++) begin
                wr(9'h150, (32'(c % 2) << ch) | (32'(c / 2) << (ch + 16)));
                chk("R9 loop needs both bits", 32'(ch_loop_o), (c == 3) ? (32'(1) << ch) : 32'h0);
            end
        end
        wr(9'h150, 32'hFFFF_FFFF);
        rd(9'h150, v); chk("R9 loop readback", v, 32'hFFFF_FFFF);
        chk("R9 all loop on", 32'(ch_loop_o), 32'h0000_FFFF);
        wr(9'h15C, 32'h0001_0002);
        rd(9'h150, v); chk("R9 clear alias", v, 32'hFFFE_FFFD);
        chk("R9 loop off after clear", 32'(ch_loop_o), 32'h0000_FFFC);
        wr(9'h15C, 32'h0);
        rd(9'h150, v); chk("R9 zeros no effect", v, 32'hFFFE_FFFD);
        rd(9'h15C, v); chk("R9 alias reads zero", v, 32'h0);

        // R11: unused offsets
        wr(9'h148, 32'h0000_1234);
        for (int a = 9'h154; a < 512; a += 4) begin
            if (a == 9'h15C) continue;
            wr(9'(a), 32'hFFFF_FFFF);
            chk("R11 no pulse from unused write", 32'({snap_start, snap_stop}), 32'h0);
            rd(9'(a), v); chk("R11 unused reads zero", v, 32'h0);
        end
        rd(9'h148, v); chk("R11 enable untouched", v, 32'h0000_1234);
        rd(9'h150, v); chk("R11 loop untouched", v, 32'hFFFE_FFFD);
        rd(9'h144, v); chk("R11 status untouched", v, 32'h0);
        rd(9'h004, v); chk("R11 channel untouched", v, 32'h0000_0001);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule